// File: doc/BRIEF.md
# Memory-Mapped Character FIFO Port

This block connects a processor bus to two byte streams through a pair of 64-entry first-in first-out buffers. Characters that arrive on a valid/ready input stream collect in a receive buffer. Characters that the processor writes collect in a transmit buffer, which a valid/ready output stream drains. The processor sees two 32-bit registers. One is a data word: a read takes one character and a write queues one character. The other is a control word that reports free transmit space.

A single read of the data word does three things. It removes the oldest received character. It raises a flag that says whether a character was really returned. It reports how many characters are still waiting. Software can therefore empty the receive side without a separate status poll. Before it queues output, software reads the control word to learn how much transmit space is left.

Both bus registers return their value on the clock edge after the access. All far-side outputs come straight from registers.

Top module: `char_fifo_port`

## Requirements
- R1: While rst_n is low at a rising edge, the block clears itself. After that edge, bus_rdata is 0, tx_out_valid is 0, rx_in_ready is 1 and the control word reports 64 free entries.
- R2: A read of byte offset 0 while the receive buffer holds data removes its oldest entry. On the next edge, bus_rdata[15] is 1 and bus_rdata[7:0] carries that character, and characters come out in arrival order.
- R3: A read of offset 0 places the receive entry count in bus_rdata[31:16]. This count is taken after the read's removal and after any far-side arrival accepted in the same cycle.
- R4: A read of offset 0 with the receive buffer empty returns bit 15 as 0 and bits 7:0 as 0, and removes nothing.
- R5: A read of byte offset 4 returns, in bits 31:16, 64 minus the transmit entry count after that cycle's operations, and returns 0 in bits 15:0. Reads of any other offset return 0.
- R6: A write to offset 0 appends bus_wdata[7:0] to the transmit buffer and ignores bits 31:8. The transmit buffer presents bytes on tx_out_data in write order while tx_out_valid is 1. A byte leaves on every cycle in which tx_out_valid and tx_out_ready are both 1.
- R7: A write to offset 0 while the transmit buffer holds 64 entries is dropped. The free count stays 0 and the byte never appears on tx_out_data.
- R8: rx_in_ready is 0 while the receive buffer holds 64 entries. A far-side character offered in that state is discarded.
- R9: Writes to offset 4 and to unmapped offsets change neither buffer.
- R10: A push is accepted only if the buffer was not full at the start of the cycle, and a pop only if it was not empty. When both happen in one cycle, the count is unchanged, so a simultaneous read and arrival on an empty buffer returns bit 15 as 0 with a count of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Byte offset: 0 data word, 4 control word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, updated the edge after a read and held otherwise |
| rx_in_valid | input | 1 | Far side offers a received character |
| rx_in_data | input | 8 | Offered character |
| rx_in_ready | output | 1 | Receive buffer can accept |
| tx_out_valid | output | 1 | Transmit buffer has a character |
| tx_out_data | output | 8 | Oldest transmit character |
| tx_out_ready | input | 1 | Far side takes the character |

## Verification
Every result is due one rising edge after the cycle that caused it. A read's bus_rdata is due at that edge. A write or a far-side push or pop shows on tx_out_valid, tx_out_data and rx_in_ready at that edge. The bench drives inputs on falling edges and updates a queue-based model on each rising edge. It compares outputs at the following falling edge, so each result is judged exactly one edge after its cause. Directed sequences then check hand-computed words for the full, empty and simultaneous push-and-pop cases at those same sample points.

// File: rtl/cfp_pkg.sv
// Package: shared register offsets and word layouts for the character FIFO port.
// Assumes a bus with 3-bit byte offsets and 32-bit data words.
package cfp_pkg;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_CTRL = 3'd4;

    // Data word as returned by a read of OFS_DATA.
    typedef struct packed {
        logic [15:0] avail;   // entries left after the read
        logic        valid;   // a character was returned
        logic [6:0]  rsvd;
        logic [7:0]  char_q;  // received character
    } data_word_t;

    // Control word as returned by a read of OFS_CTRL.
    typedef struct packed {
        logic [15:0] space;   // free transmit entries
        logic [15:0] rsvd;
    } ctrl_word_t;

endpackage

// File: rtl/cfp_fifo.sv
// Synchronous FIFO with an occupancy count and a look-ahead count.
// A push is accepted only if the FIFO is not full at the start of the cycle.
// A pop is accepted only if it is not empty at the start of the cycle.
// cnt_nxt is the count after this cycle's accepted operations.
// The storage is not reset, and head is meaningful only while empty is 0.
module cfp_fifo #(
    parameter  int WIDTH = 8,
    parameter  int DEPTH = 64,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_req,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    cnt,
    output logic [CW-1:0]    cnt_nxt,
    output logic             full,
    output logic             empty
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == FULL_CNT);
    assign empty   = (cnt == '0);
    assign push_ok = push_req && !full;
    assign pop_ok  = pop_req && !empty;
    assign head    = mem[rd_ptr];

    // Purpose: occupancy after this cycle's accepted push and pop.
    always_comb begin
        unique case ({push_ok, pop_ok})
            2'b10:   cnt_nxt = cnt + 1'b1;
            2'b01:   cnt_nxt = cnt - 1'b1;
            default: cnt_nxt = cnt;
        endcase
    end

    // Purpose: advance the pointers and the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            cnt <= cnt_nxt;
        end
    end

    // Purpose: store an accepted character.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/cfp_regs.sv
// Register front end of the character FIFO port.
// Decodes one bus access per cycle into pop and push requests.
// Forms the read word from the FIFOs' look-ahead counts.
// bus_rdata is registered, changes only on a read, and holds otherwise.
module cfp_regs
    import cfp_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [2:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          rx_pop,
    output logic          tx_push,
    output logic [7:0]    tx_byte,
    input  logic [7:0]    rx_head,
    input  logic          rx_empty,
    input  logic [CW-1:0] rx_cnt_nxt,
    input  logic [CW-1:0] tx_cnt_nxt
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic       rd_data;
    logic       rd_ctrl;
    logic       rd_any;
    logic       unused_wdata_hi;
    data_word_t dword;
    ctrl_word_t cword;

    assign rd_any          = bus_sel && !bus_wr;
    assign rd_data         = rd_any && (bus_addr == OFS_DATA);
    assign rd_ctrl         = rd_any && (bus_addr == OFS_CTRL);
    assign tx_push         = bus_sel && bus_wr && (bus_addr == OFS_DATA);
    assign rx_pop          = rd_data;
    assign tx_byte         = bus_wdata[7:0];
    assign unused_wdata_hi = ^bus_wdata[31:8];

    // Purpose: assemble the data word seen by a read of offset 0.
    always_comb begin
        dword        = '0;
        dword.avail  = 16'(rx_cnt_nxt);
        dword.valid  = !rx_empty;
        dword.char_q = rx_empty ? 8'h00 : rx_head;
    end

    // Purpose: assemble the control word seen by a read of offset 4.
    always_comb begin
        cword       = '0;
        cword.space = 16'(FULL_CNT - tx_cnt_nxt);
    end

    // Purpose: capture the read word on a read and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_any) begin
            if (rd_data)      bus_rdata <= dword;
            else if (rd_ctrl) bus_rdata <= cword;
            else              bus_rdata <= '0;
        end
    end

endmodule

// File: rtl/char_fifo_port.sv
// Top of the character FIFO port.
// A receive FIFO is filled from a valid/ready stream and drained by bus reads.
// A transmit FIFO is filled by bus writes and drained to a valid/ready stream.
// Assumes at most one bus access per cycle.
module char_fifo_port #(
    parameter  int DEPTH = 64,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rx_in_valid,
    input  logic [7:0]  rx_in_data,
    output logic        rx_in_ready,
    output logic        tx_out_valid,
    output logic [7:0]  tx_out_data,
    input  logic        tx_out_ready
);

    logic          rx_pop;
    logic          tx_push;
    logic [7:0]    tx_byte;
    logic [7:0]    rx_head;
    logic [CW-1:0] rx_cnt;
    logic [CW-1:0] rx_cnt_nxt;
    logic [CW-1:0] tx_cnt;
    logic [CW-1:0] tx_cnt_nxt;
    logic          rx_full;
    logic          rx_empty;
    logic          tx_full;
    logic          tx_empty;
    logic          unused_tx_full;

    assign rx_in_ready    = !rx_full;
    assign tx_out_valid   = !tx_empty;
    assign unused_tx_full = tx_full;

    cfp_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (rx_in_valid),
        .push_data (rx_in_data),
        .pop_req   (rx_pop),
        .head      (rx_head),
        .cnt       (rx_cnt),
        .cnt_nxt   (rx_cnt_nxt),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    cfp_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (tx_push),
        .push_data (tx_byte),
        .pop_req   (tx_out_ready),
        .head      (tx_out_data),
        .cnt       (tx_cnt),
        .cnt_nxt   (tx_cnt_nxt),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    cfp_regs #(.DEPTH(DEPTH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .rx_pop     (rx_pop),
        .tx_push    (tx_push),
        .tx_byte    (tx_byte),
        .rx_head    (rx_head),
        .rx_empty   (rx_empty),
        .rx_cnt_nxt (rx_cnt_nxt),
        .tx_cnt_nxt (tx_cnt_nxt)
    );

endmodule

// File: rtl/cfp_checker.sv
// Assertion checker for char_fifo_port, attached by the bind at the end of this file.
// It observes the ports and the two FIFO occupancy counts.
module cfp_checker #(
    parameter  int DEPTH = 64,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [2:0]    bus_addr,
    input logic [31:0]   bus_rdata,
    input logic          rx_in_ready,
    input logic          tx_out_valid,
    input logic          tx_out_ready,
    input logic [CW-1:0] rx_cnt,
    input logic [CW-1:0] tx_cnt
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic rd_dat;
    logic rd_ctl;
    logic wr_dat;
    logic wr_other;
    logic tx_leaving;

    assign rd_dat     = bus_sel && !bus_wr && (bus_addr == 3'd0);
    assign rd_ctl     = bus_sel && !bus_wr && (bus_addr == 3'd4);
    assign wr_dat     = bus_sel && bus_wr && (bus_addr == 3'd0);
    assign wr_other   = bus_sel && bus_wr && (bus_addr != 3'd0);
    assign tx_leaving = tx_out_valid && tx_out_ready;

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (bus_rdata == 32'h0) && !tx_out_valid && rx_in_ready);

    a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dat && rx_cnt != '0) |=> bus_rdata[15]);

    a_r3_count_field: assert property (@(posedge clk) disable iff (!rst_n)
        rd_dat |=> bus_rdata[31:16] == 16'(rx_cnt));

    a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dat && rx_cnt == '0) |=> !bus_rdata[15] && bus_rdata[7:0] == 8'h00);

    a_r5_space_field: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctl |=> bus_rdata[31:16] == 16'(FULL_CNT - tx_cnt) && bus_rdata[15:0] == 16'h0);

    a_r6_tx_push: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && tx_cnt != FULL_CNT && !tx_leaving) |=> tx_cnt == $past(tx_cnt) + 1'b1);

    a_r7_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && tx_cnt == FULL_CNT && !tx_out_ready) |=> tx_cnt == FULL_CNT);

    a_r8_rx_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == FULL_CNT) |-> !rx_in_ready);

    a_r9_other_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_other && !tx_leaving) |=> $stable(tx_cnt));

    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= FULL_CNT && tx_cnt <= FULL_CNT);

endmodule

bind char_fifo_port cfp_checker #(.DEPTH(DEPTH)) u_cfp_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .rx_in_ready  (rx_in_ready),
    .tx_out_valid (tx_out_valid),
    .tx_out_ready (tx_out_ready),
    .rx_cnt       (rx_cnt),
    .tx_cnt       (tx_cnt)
);

// File: tb/test_char_fifo_port.sv
// Bench for char_fifo_port.
// A queue model, updated on each rising edge, is compared on each falling edge.
// Directed sequences check hand-computed words.
module test_char_fifo_port;

    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        rx_in_valid = 1'b0;
    logic [7:0]  rx_in_data = 8'h0;
    logic        rx_in_ready;
    logic        tx_out_valid;
    logic [7:0]  tx_out_data;
    logic        tx_out_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 1'b0;

    logic [7:0]  rxq[$];
    logic [7:0]  txq[$];
    logic [31:0] exp_rdata = 32'h0;

    char_fifo_port #(.DEPTH(DEPTH)) i_char_fifo_port (.*);

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Reference model: applies each cycle's accepted operations at the rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            rxq.delete();
            txq.delete();
            exp_rdata = 32'h0;
            started = 1'b1;
        end else begin
            bit rdh, rdc, wrd, rxp, rxpop, txpush, txpop;
            logic [7:0] ch;
            ch     = 8'h00;
            rdh    = bus_sel && !bus_wr && bus_addr == 3'd0;
            rdc    = bus_sel && !bus_wr && bus_addr == 3'd4;
            wrd    = bus_sel && bus_wr && bus_addr == 3'd0;
            rxp    = rx_in_valid && rxq.size() < DEPTH;
            rxpop  = rdh && rxq.size() > 0;
            txpush = wrd && txq.size() < DEPTH;
            txpop  = tx_out_ready && txq.size() > 0;
            if (rxpop) ch = rxq.pop_front();
            if (rxp) rxq.push_back(rx_in_data);
            if (txpop) void'(txq.pop_front());
            if (txpush) txq.push_back(bus_wdata[7:0]);
            if (rdh) exp_rdata = {16'(rxq.size()), rxpop, 7'b0, ch};
            else if (rdc) exp_rdata = {16'(DEPTH - txq.size()), 16'h0};
            else if (bus_sel && !bus_wr) exp_rdata = 32'h0;
        end
    end

    // Per-cycle comparison one edge after each cause (R2 R3 R5 R6 R8).
    always @(negedge clk) begin
        if (started) begin
            check(bus_rdata == exp_rdata, "R2 R3 R5 model rdata", bus_rdata, exp_rdata);
            check(tx_out_valid == (txq.size() > 0), "R6 model tx_out_valid",
                  32'(tx_out_valid), 32'(txq.size() > 0));
            if (txq.size() > 0)
                check(tx_out_data == txq[0], "R6 model tx_out_data", 32'(tx_out_data), 32'(txq[0]));
            check(rx_in_ready == (rxq.size() < DEPTH), "R8 model rx_in_ready",
                  32'(rx_in_ready), 32'(rxq.size() < DEPTH));
        end
    end

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic read_with_push(input logic [7:0] b, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd0;
        rx_in_valid = 1'b1; rx_in_data = b;
        @(negedge clk);
        bus_sel = 1'b0; rx_in_valid = 1'b0;
        d = bus_rdata;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual %0d expected 0 cycles left", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  got[$];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(bus_rdata == 32'h0, "R1 rdata after reset", bus_rdata, 32'h0);
        check(!tx_out_valid && rx_in_ready, "R1 stream flags", {tx_out_valid, rx_in_ready}, 32'h1);
        bus_read(3'd4, d);
        check(d == 32'h0040_0000, "R1 R5 control after reset", d, 32'h0040_0000);

        // R4: empty read
        bus_read(3'd0, d);
        check(d == 32'h0, "R4 empty read", d, 32'h0);

        // R2 R3: three characters in arrival order
        @(negedge clk);
        rx_in_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            rx_in_data = 8'hA0 + 8'(i);
            @(negedge clk);
        end
        rx_in_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            bus_read(3'd0, d);
            check(d == {16'(2 - i), 1'b1, 7'b0, 8'hA0 + 8'(i)}, "R2 R3 ordered read", d,
                  {16'(2 - i), 1'b1, 7'b0, 8'hA0 + 8'(i)});
        end
        bus_read(3'd0, d);
        check(d == 32'h0, "R4 read after drain", d, 32'h0);

        // R5 R6: one write, upper bits ignored
        bus_write(3'd0, 32'hABCD_125A);
        check(tx_out_valid && tx_out_data == 8'h5A, "R6 tx byte", 32'(tx_out_data), 32'h5A);
        bus_read(3'd4, d);
        check(d == 32'h003F_0000, "R5 space after one write", d, 32'h003F_0000);
        bus_read(3'd2, d);
        check(d == 32'h0, "R5 unmapped read", d, 32'h0);

        // R7: fill, then overfill
        for (int i = 1; i < DEPTH; i++) bus_write(3'd0, 32'(i));
        bus_read(3'd4, d);
        check(d == 32'h0, "R7 space at full", d, 32'h0);
        bus_write(3'd0, 32'h0000_00EE);
        bus_read(3'd4, d);
        check(d == 32'h0, "R7 space after dropped write", d, 32'h0);

        // R6 R7: drain in order, the dropped byte absent
        tx_out_ready = 1'b1;
        for (int i = 0; i < DEPTH + 6; i++) begin
            if (tx_out_valid) got.push_back(tx_out_data);
            @(negedge clk);
        end
        tx_out_ready = 1'b0;
        check(got.size() == DEPTH, "R7 drained count", 32'(got.size()), 32'(DEPTH));
        check(got[0] == 8'h5A && got[DEPTH-1] == 8'(DEPTH - 1), "R6 drained order",
              {got[0], got[DEPTH-1]}, {8'h5A, 8'(DEPTH - 1)});

        // R9: control-offset and unmapped writes ignored
        bus_write(3'd4, 32'hFFFF_FFFF);
        bus_write(3'd6, 32'h0000_0033);
        check(!tx_out_valid, "R9 no tx after other writes", 32'(tx_out_valid), 32'h0);
        bus_read(3'd4, d);
        check(d == 32'h0040_0000, "R9 space unchanged", d, 32'h0040_0000);

        // R8: receive overflow
        @(negedge clk);
        rx_in_valid = 1'b1;
        for (int i = 0; i < DEPTH + 6; i++) begin
            rx_in_data = 8'(i);
            @(negedge clk);
        end
        rx_in_valid = 1'b0;
        check(!rx_in_ready, "R8 ready low at full", 32'(rx_in_ready), 32'h0);

        // R10: read and push at full, push refused
        read_with_push(8'hF0, d);
        check(d == 32'h003F_8000, "R10 read at full with push", d, 32'h003F_8000);
        // R10 R3: read and push below full, count unchanged
        read_with_push(8'hF1, d);
        check(d == 32'h003F_8001, "R10 R3 read with accepted push", d, 32'h003F_8001);
        for (int k = 0; k < 62; k++) begin
            bus_read(3'd0, d);
            check(d == {16'(62 - k), 1'b1, 7'b0, 8'(2 + k)}, "R2 R3 drain", d,
                  {16'(62 - k), 1'b1, 7'b0, 8'(2 + k)});
        end
        bus_read(3'd0, d);
        check(d == 32'h0000_80F1, "R2 last entry", d, 32'h0000_80F1);

        // R10 R4: read and push on empty
        read_with_push(8'h77, d);
        check(d == 32'h0001_0000, "R10 R4 empty read with push", d, 32'h0001_0000);
        bus_read(3'd0, d);
        check(d == 32'h0000_8077, "R10 pushed byte readable", d, 32'h0000_8077);

        // R1: reset mid-traffic
        bus_write(3'd0, 32'h11);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(!tx_out_valid && bus_rdata == 32'h0, "R1 reset clears", bus_rdata, 32'h0);

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule